// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Divider

This block divides a fast input clock into a slower output clock whose high time and low time are programmed independently, each as a count of input clock cycles stored in minus-one form. A shared, active-high synchronization request lets many such dividers be aligned. While the request is active the divider parks its output at a selectable static level and clears its counting. When the request is released it waits a programmable number of input cycles (the phase offset) and then starts counting in a selectable starting level.

Further configuration inputs let a divider be bypassed, in which case the input clock appears directly at the output. They also let a divider ignore the shared synchronization request, and, together with that, hold the output at a static high level. Count changes made while the divider runs are picked up only at the next phase boundary or the next release, so a reprogramming never produces a partial phase.

All divider state sits in the input clock domain, with a synchronous active-high reset. The output is registered, except in bypass, where it is the input clock itself.

Top module: `cdiv_top`

## Requirements
- R1: While `rst` is high, the registered output is driven low at every clock edge, and the divider is parked. The first edge with `rst` low and no hold condition acts as a synchronization release.
- R2: While running, each low phase of `clk_out` lasts `cfg_lo_cnt`+1 input cycles.
- R3: While running, each high phase of `clk_out` lasts `cfg_hi_cnt`+1 input cycles, so the divide ratio is (`cfg_lo_cnt`+1)+(`cfg_hi_cnt`+1).
- R4: After a release, the first phase has the level given by `cfg_start_hi` (1 = high, 0 = low). It is then followed by the opposite level.
- R5: With `cfg_phase` = P, the starting level appears P input cycles after the first edge of the release. Until then `clk_out` keeps the static hold level.
- R6: While `sync_req` is 1 and `cfg_ign_sync` is 0, `clk_out` holds the level of `cfg_force_hi` (1 = high, 0 = low) from the following edge on, and counting restarts on release.
- R7: With `cfg_ign_sync` = 1 and `cfg_force_hi` = 0, `sync_req` has no effect: the output continues the same high/low pattern.
- R8: With `cfg_ign_sync` = 1 and `cfg_force_hi` = 1, `clk_out` is held statically high whatever `sync_req` does.
- R9: With `cfg_bypass` = 1, `clk_out` equals `clk`. Clearing it acts as a synchronization release.
- R10: A change of `cfg_lo_cnt` or `cfg_hi_cnt` while running does not alter the phase in progress. It takes effect from the next phase of that level.
- R11: With both counts 0, the output toggles on every input clock edge (divide by two).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_req | input | 1 | Shared synchronization request, active high |
| cfg_lo_cnt | input | CNT_W | Low-phase length minus one |
| cfg_hi_cnt | input | CNT_W | High-phase length minus one |
| cfg_bypass | input | 1 | 1 routes the input clock to the output |
| cfg_ign_sync | input | 1 | 1 makes this divider ignore `sync_req` |
| cfg_force_hi | input | 1 | Static hold level (1 high, 0 low) |
| cfg_start_hi | input | 1 | Level of the first phase after release |
| cfg_phase | input | PH_W | Input cycles of delay after release |
| clk_out | output | 1 | Divided clock |

## Verification
A wrong count in either counter shows at the port as a phase that is one or more input cycles too long or too short. This is visible within one output period of the release. A wrong state after release shows as the starting level appearing early or late, or at the wrong level, on the first samples after `sync_req` falls. A divider that wrongly obeys or ignores synchronization shows as a break in the expected pattern within a cycle of the `sync_req` edge. The bench compares every sampled cycle against a pattern computed from the counts, start level and offset.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } cdiv_state_t;
endpackage

// File: rtl/cdiv_down_cnt.sv
module cdiv_down_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         is_zero
);
  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= load_val;
    else if (dec && q != '0) q <= q - 1'b1;
  end

  assign is_zero = (q == '0);
endmodule

// File: rtl/cdiv_out_sel.sv
module cdiv_out_sel (
  input  logic clk,
  input  logic bypass,
  input  logic div_q,
  output logic clk_out
);
  assign clk_out = bypass ? clk : div_q;
endmodule

// File: rtl/cdiv_top.sv
module cdiv_top #(
  parameter int CNT_W = 4,
  parameter int PH_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_req,
  input  logic [CNT_W-1:0] cfg_lo_cnt,
  input  logic [CNT_W-1:0] cfg_hi_cnt,
  input  logic             cfg_bypass,
  input  logic             cfg_ign_sync,
  input  logic             cfg_force_hi,
  input  logic             cfg_start_hi,
  input  logic [PH_W-1:0]  cfg_phase,
  output logic             clk_out
);
  import cdiv_pkg::*;

  localparam logic [PH_W-1:0] PH_ONE = PH_W'(1);

  cdiv_state_t st, st_d;
  logic out_q, out_d;
  logic start_q;
  logic idle;

  logic             w_load, w_dec, w_zero;
  logic [CNT_W-1:0] w_val;
  logic             p_load, p_dec, p_zero;
  logic [PH_W-1:0]  p_val;

  // Hold condition: bypass, the forced static level, or an obeyed sync request.
  assign idle = cfg_bypass | (cfg_ign_sync ? cfg_force_hi : sync_req);

  always_comb begin
    st_d   = st;
    out_d  = out_q;
    w_load = 1'b0;
    w_val  = cfg_lo_cnt;
    w_dec  = 1'b0;
    p_load = 1'b0;
    p_val  = cfg_phase - PH_ONE;
    p_dec  = 1'b0;
    if (idle) begin
      st_d  = ST_HOLD;
      out_d = cfg_force_hi;
    end else begin
      case (st)
        ST_HOLD: begin
          if (cfg_phase == '0) begin
            out_d  = cfg_start_hi;
            w_load = 1'b1;
            w_val  = cfg_start_hi ? cfg_hi_cnt : cfg_lo_cnt;
            st_d   = ST_RUN;
          end else begin
            p_load = 1'b1;
            st_d   = ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (p_zero) begin
            out_d  = start_q;
            w_load = 1'b1;
            w_val  = start_q ? cfg_hi_cnt : cfg_lo_cnt;
            st_d   = ST_RUN;
          end else begin
            p_dec = 1'b1;
          end
        end
        ST_RUN: begin
          if (w_zero) begin
            out_d  = ~out_q;
            w_load = 1'b1;
            w_val  = out_q ? cfg_lo_cnt : cfg_hi_cnt;
          end else begin
            w_dec = 1'b1;
          end
        end
        default: st_d = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_HOLD;
      out_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      st    <= st_d;
      out_q <= out_d;
      if (st == ST_HOLD && !idle) start_q <= cfg_start_hi;
    end
  end

  cdiv_down_cnt #(.W(CNT_W)) u_width_cnt (
    .clk(clk), .rst(rst), .load(w_load), .load_val(w_val),
    .dec(w_dec), .is_zero(w_zero)
  );

  cdiv_down_cnt #(.W(PH_W)) u_phase_cnt (
    .clk(clk), .rst(rst), .load(p_load), .load_val(p_val),
    .dec(p_dec), .is_zero(p_zero)
  );

  cdiv_out_sel u_out_sel (
    .clk(clk), .bypass(cfg_bypass), .div_q(out_q), .clk_out(clk_out)
  );
endmodule

// File: rtl/cdiv_checker.sv
module cdiv_checker (
  input logic             clk,
  input logic             rst,
  input logic             sync_req,
  input logic             cfg_bypass,
  input logic             cfg_ign_sync,
  input logic             cfg_force_hi,
  input logic             out_q,
  input logic             start_q,
  input cdiv_pkg::cdiv_state_t st,
  input logic             clk_out
);
  import cdiv_pkg::*;

  AST_RESET_LOW: assert property (@(posedge clk)
    $past(rst) |-> !out_q); // R1

  AST_HOLD_LEVEL: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(sync_req && !cfg_ign_sync && !cfg_bypass))
      |-> out_q == $past(cfg_force_hi)); // R6

  AST_FORCED_HIGH: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(cfg_ign_sync && cfg_force_hi && !cfg_bypass))
      |-> out_q); // R8

  AST_WAIT_STEADY: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && st == ST_WAIT && $past(st) == ST_WAIT)
      |-> $stable(out_q)); // R5

  AST_FIRST_LEVEL: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && st == ST_RUN && $past(st) == ST_WAIT)
      |-> out_q == start_q); // R4

  AST_SYNC_IGNORED: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(cfg_ign_sync && !cfg_force_hi && !cfg_bypass)
      && $past(st) != ST_HOLD && cfg_ign_sync && !cfg_force_hi && !cfg_bypass)
      |=> st != ST_HOLD); // R7

  always @(negedge clk) begin
    if (!rst && cfg_bypass)
      AST_BYPASS_ROUTE: assert (clk_out == 1'b0); // R9
  end
endmodule

bind cdiv_top cdiv_checker u_cdiv_checker (
  .clk(clk), .rst(rst), .sync_req(sync_req), .cfg_bypass(cfg_bypass),
  .cfg_ign_sync(cfg_ign_sync), .cfg_force_hi(cfg_force_hi),
  .out_q(out_q), .start_q(start_q), .st(st), .clk_out(clk_out)
);

// File: tb/cdiv_top_tb.sv
module cdiv_top_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sync_req = 1'b1;
  logic [3:0] cfg_lo_cnt = 4'd7;
  logic [3:0] cfg_hi_cnt = 4'd7;
  logic       cfg_bypass = 1'b0;
  logic       cfg_ign_sync = 1'b0;
  logic       cfg_force_hi = 1'b0;
  logic       cfg_start_hi = 1'b0;
  logic [3:0] cfg_phase = 4'd0;
  logic       clk_out;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cdiv_top u_dut (
    .clk(clk), .rst(rst), .sync_req(sync_req), .cfg_lo_cnt(cfg_lo_cnt),
    .cfg_hi_cnt(cfg_hi_cnt), .cfg_bypass(cfg_bypass), .cfg_ign_sync(cfg_ign_sync),
    .cfg_force_hi(cfg_force_hi), .cfg_start_hi(cfg_start_hi), .cfg_phase(cfg_phase),
    .clk_out(clk_out)
  );

  // Expected level k samples after the first release edge.
  function automatic logic exp_lvl(int k, int n, int m, bit s, int p, bit f);
    int j, t, first;
    if (k < p) return f;
    j = k - p;
    t = n + m + 2;
    first = s ? m + 1 : n + 1;
    return ((j % t) < first) ? s : ~s;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: clk_out=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Park under sync, verify hold level, release, then follow the pattern.
  task automatic run_case(int n, int m, bit s, int p, bit f, string req);
    sync_req = 1'b1; cfg_ign_sync = 1'b0; cfg_bypass = 1'b0;
    cfg_lo_cnt = 4'(n); cfg_hi_cnt = 4'(m); cfg_start_hi = s;
    cfg_phase = 4'(p); cfg_force_hi = f;
    repeat (3) @(negedge clk);
    chk("R6", clk_out, f);
    sync_req = 1'b0;
    for (int k = 0; k < p + 2 * (n + m + 2) + 2; k++) begin
      @(negedge clk);
      chk(req, clk_out, exp_lvl(k, n, m, s, p, f));
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_cd17));
    repeat (4) @(negedge clk);
    chk("R1", clk_out, 1'b0);
    rst = 1'b0;

    // Directed corners
    run_case(0, 0, 0, 0, 0, "R11");
    run_case(0, 0, 1, 3, 1, "R11");
    run_case(5, 2, 0, 0, 0, "R2");
    run_case(2, 6, 1, 0, 0, "R3");
    run_case(3, 1, 1, 7, 0, "R5");
    run_case(15, 15, 0, 15, 1, "R4");

    // Random cases against the reference pattern
    for (int i = 0; i < 40; i++) begin
      int n, m, p;
      bit s, f;
      n = int'($urandom_range(0, 15));
      m = int'($urandom_range(0, 15));
      p = int'($urandom_range(0, 15));
      s = 1'($urandom_range(0, 1));
      f = 1'($urandom_range(0, 1));
      run_case(n, m, s, p, f, "R2/R3 random");
    end

    // R7: ignored sync toggling must not disturb the pattern
    sync_req = 1'b1; cfg_ign_sync = 1'b0; cfg_force_hi = 1'b0;
    cfg_lo_cnt = 4'd2; cfg_hi_cnt = 4'd4; cfg_start_hi = 1'b1; cfg_phase = 4'd2;
    repeat (3) @(negedge clk);
    cfg_ign_sync = 1'b1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      chk("R7", clk_out, exp_lvl(k, 2, 4, 1'b1, 2, 1'b0));
      sync_req = 1'($urandom_range(0, 1));
    end

    // R8: ignore plus force high gives a static high level
    cfg_force_hi = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 12; k++) begin
      sync_req = 1'($urandom_range(0, 1));
      @(negedge clk);
      chk("R8", clk_out, 1'b1);
    end

    // R10: a count change mid-phase waits for the next phase of that level
    sync_req = 1'b1; cfg_ign_sync = 1'b0; cfg_force_hi = 1'b0;
    cfg_lo_cnt = 4'd3; cfg_hi_cnt = 4'd3; cfg_start_hi = 1'b0; cfg_phase = 4'd0;
    repeat (3) @(negedge clk);
    sync_req = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      case (k)
        0, 3:    chk("R10", clk_out, 1'b0);
        4, 7, 9: chk("R10", clk_out, 1'b1);
        8:       chk("R10", clk_out, 1'b0);
        default: ;
      endcase
      if (k == 1) cfg_lo_cnt = 4'd0;
    end

    // R9: bypass routes the input clock
    cfg_bypass = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #5;
      chk("R9", clk_out, 1'b1);
      @(negedge clk); #5;
      chk("R9", clk_out, 1'b0);
    end
    // R9: clearing bypass releases like a sync
    cfg_lo_cnt = 4'd1; cfg_hi_cnt = 4'd2; cfg_start_hi = 1'b1; cfg_phase = 4'd1;
    @(negedge clk);
    cfg_bypass = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk("R9", clk_out, exp_lvl(k, 1, 2, 1'b1, 1, 1'b0));
    end

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end
endmodule